// File: doc/BRIEF.md
# Post-Reset Start-Up Sequencer

This block orders a processor's start-up once its reset is released. After a normal release it runs five phases in turn. A fixed settling wait comes first, then a scan for a preset memory-interface setting. A burst of configuration reads to external memory follows, then a wait whose length comes from the configuration just read. Last comes a block of DRAM refresh cycles. When refresh is turned off in that configuration, the refresh block is replaced by an idle period of the same length with no memory activity. The block then hands control to a bootstrap from ROM or to a wait for a boot byte on a link.

A debug-halt release follows a shorter path. If the analyse input is high on the clock edge where reset is released, no configuration work and no refresh take place, and the stored configuration is left alone. Booting is held back until analyse is seen low. Read and refresh cycles are counted by a one-cycle acknowledge from the memory interface. The wait length and the length of one refresh cycle are given to the block as inputs. The memory bus timing, the refresh engine and the core itself sit outside this block.

Top module: `bootseq_top`

## Requirements
- R1: `link_hold_o` is high in every cycle after a clock edge that samples `rst_n` low, until the first edge that samples `rst_n` high. At all other times it is low.
- R2: `phase_o` encodes the phase: 0 reset, 1 settle, 2 scan, 3 config read, 4 config wait, 5 refresh, 6 refresh-idle, 7 analyse hold, 8 boot. After a normal release edge (analyse low), the settle phase lasts exactly `SETTLE_CYC` (144) cycles, starting in the cycle after that edge.
- R3: The scan phase follows directly and lasts exactly `SCAN_CYC` (144) cycles.
- R4: In the config-read phase `cfg_rd_req_o` is high, and the phase ends on the clock edge that samples the `CFG_READS`-th (36th) high `mem_ack_i`. `mem_ack_i` in any timed phase has no effect on phase lengths.
- R5: On the edge that ends the config-read phase, `wait_len_i`, `ref_len_i` and `refresh_en_i` are latched, and `cfg_upd_o` pulses in the next cycle. The config-wait phase then lasts the latched wait length in cycles, with 0 treated as 1. Later changes to these inputs have no effect on the current run.
- R6: With latched refresh enable high, the refresh phase drives `ref_req_o` high and ends on the edge that samples the `REF_BURST`-th (8th) `mem_ack_i`.
- R7: With latched refresh enable low, the refresh-idle phase lasts `REF_BURST` times the latched refresh length in cycles (0 treated as 1), and `ref_req_o` and `cfg_rd_req_o` stay low.
- R8: On the edge that ends the refresh phase or the refresh-idle phase, `boot_sel_o` is set to 2'b01 (ROM) if `boot_rom_i` is high, or to 2'b10 (link) if it is low. It then holds that value until reset, whatever `boot_rom_i` does.
- R9: `flag_clr_o` pulses for exactly the first cycle after a normal release. It never pulses after an analyse release.
- R10: After an analyse release the phase is analyse hold. In this phase there is no config read, no refresh, no `cfg_upd_o` and no `boot_sel_o`. The first edge that samples `analyse_i` low enters boot, with `boot_sel_o` chosen from `boot_rom_i` at that edge as in R8.
- R11: Sampling `rst_n` low in any phase returns the block to the reset phase in the next cycle, which abandons the run.
- R12: At most one of `cfg_rd_req_o`, `ref_req_o`, `boot_sel_o[0]` and `boot_sel_o[1]` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low processor reset; its release starts the sequence |
| analyse_i | input | 1 | Debug-halt qualifier for reset |
| boot_rom_i | input | 1 | High selects a ROM boot, low a link boot |
| refresh_en_i | input | 1 | Refresh enable in the configuration being read |
| wait_len_i | input | WAIT_W | Configuration-dependent wait length in cycles |
| ref_len_i | input | REFLEN_W | Length of one refresh cycle in clock cycles |
| mem_ack_i | input | 1 | One-cycle completion strobe from the memory interface |
| phase_o | output | 4 | Current phase code |
| cfg_rd_req_o | output | 1 | Configuration reads requested |
| ref_req_o | output | 1 | Refresh cycles requested |
| cfg_upd_o | output | 1 | One-cycle strobe: new configuration latched |
| flag_clr_o | output | 1 | One-cycle strobe clearing the error/halt/break flags |
| link_hold_o | output | 1 | Holds link outputs low |
| boot_sel_o | output | 2 | Boot mode: 01 ROM, 10 link, 00 none yet |

## Verification
The embedded assertions check several rules on every cycle. The phase counter never runs past the limit of its phase. The request and boot outputs are mutually exclusive. The boot mode stays stable once chosen, and the link hold appears only in the reset phase. The refresh-versus-idle choice matches the latched enable, the stored configuration does not change outside its load, and the analyse hold can only exit into boot. Only the bench scenarios can show the exact length of every phase, the effect of acknowledges on the counted phases, zero-length clamping, the sampling points of the configuration and boot inputs, the strobe timing, and the abort on a reset that arrives mid-sequence.

// File: rtl/bootseq_pkg.sv
`timescale 1ns/1ps
// Shared types of the start-up sequencer.
// Assumes: phase codes are visible at the top ports and must stay fixed.
package bootseq_pkg;

    typedef enum logic [3:0] {
        PH_RST     = 4'd0,
        PH_SETTLE  = 4'd1,
        PH_SCAN    = 4'd2,
        PH_CFGRD   = 4'd3,
        PH_WAIT    = 4'd4,
        PH_REFR    = 4'd5,
        PH_REFIDLE = 4'd6,
        PH_HOLD    = 4'd7,
        PH_BOOT    = 4'd8
    } phase_e;

    typedef enum logic [1:0] {
        BOOT_NONE = 2'b00,
        BOOT_ROM  = 2'b01,
        BOOT_LINK = 2'b10
    } boot_e;

    // Larger of two values, used to size the shared counter.
    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bootseq_cnt.sv
`timescale 1ns/1ps
// Shared phase counter: counts increments up to a supplied last value.
// Assumes: the owner clears it on every phase exit, and the last value
// is stable for the whole phase.
module bootseq_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             at_last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count one step per increment; clear on phase exit or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign at_last_o = (cnt_q == last_i);

    // R2: the count never passes the limit of the current phase
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_i)
        else $error("phase counter beyond its limit");

endmodule

// File: rtl/bootseq_cfgreg.sv
`timescale 1ns/1ps
// Memory-configuration store: latches wait length, refresh length and
// refresh enable at the end of the configuration reads.
// Assumes: the stored values must survive a reset, so the data flops
// have no reset; only the update strobe is reset.
module bootseq_cfgreg #(
    parameter int WAIT_W   = 8,
    parameter int REFLEN_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [WAIT_W-1:0]   wait_len_i,
    input  logic [REFLEN_W-1:0] ref_len_i,
    input  logic                ref_en_i,
    output logic [WAIT_W-1:0]   wait_len_o,
    output logic [REFLEN_W-1:0] ref_len_o,
    output logic                ref_en_o,
    output logic                upd_o
);

    logic [WAIT_W-1:0]   wait_q;
    logic [REFLEN_W-1:0] rlen_q;
    logic                ren_q;
    logic                upd_q;

    // Capture the configuration when the read burst completes.
    always_ff @(posedge clk) begin
        if (load_i) begin
            wait_q <= wait_len_i;
            rlen_q <= ref_len_i;
            ren_q  <= ref_en_i;
        end
    end

    // One-cycle strobe after each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= load_i;
        end
    end

    assign wait_len_o = wait_q;
    assign ref_len_o  = rlen_q;
    assign ref_en_o   = ren_q;
    assign upd_o      = upd_q;

    // R10: the stored configuration changes only when loaded
    p_cfg_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(wait_q) && $stable(rlen_q) && $stable(ren_q)))
        else $error("configuration changed without a load");

    // R5: the update strobe lasts one cycle
    p_upd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q)
        else $error("update strobe longer than one cycle");

endmodule

// File: rtl/bootseq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks settle, scan, config read, wait and refresh
// (or idle), then boot; the analyse path goes through a hold instead.
// Assumes: rst_n is synchronous; the counter is cleared on each exit.
module bootseq_fsm
    import bootseq_pkg::*;
#(
    parameter int SETTLE_CYC = 144,
    parameter int SCAN_CYC   = 144,
    parameter int CFG_READS  = 36,
    parameter int REF_BURST  = 8,
    parameter int WAIT_W     = 8,
    parameter int REFLEN_W   = 6,
    parameter int CNT_W      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                analyse_i,
    input  logic                boot_rom_i,
    input  logic                ack_i,
    input  logic                at_last_i,
    input  logic [WAIT_W-1:0]   wait_len_i,
    input  logic [REFLEN_W-1:0] ref_len_i,
    input  logic                ref_en_i,
    output phase_e              phase_o,
    output logic                cnt_clr_o,
    output logic                cnt_inc_o,
    output logic [CNT_W-1:0]    cnt_last_o,
    output logic                cfg_load_o,
    output logic                link_hold_o,
    output logic                flag_clr_o,
    output boot_e               boot_o
);

    phase_e           state_q, state_d;
    boot_e            boot_q;
    logic             hold_q;
    logic             fclr_q;
    logic             adv;
    logic [CNT_W-1:0] wait_last;
    logic [CNT_W-1:0] ref_eff;
    logic [CNT_W-1:0] idle_last;

    // Zero lengths are clamped to one cycle.
    assign wait_last = (wait_len_i == '0) ? '0 : (CNT_W'(wait_len_i) - CNT_W'(1));
    assign ref_eff   = (ref_len_i == '0) ? CNT_W'(1) : CNT_W'(ref_len_i);
    assign idle_last = (CNT_W'(REF_BURST) * ref_eff) - CNT_W'(1);

    // Pick the counter limit and increment source for the current phase.
    always_comb begin
        cnt_last_o = '0;
        cnt_inc_o  = 1'b0;
        unique case (state_q)
            PH_SETTLE: begin
                cnt_last_o = CNT_W'(SETTLE_CYC - 1);
                cnt_inc_o  = 1'b1;
            end
            PH_SCAN: begin
                cnt_last_o = CNT_W'(SCAN_CYC - 1);
                cnt_inc_o  = 1'b1;
            end
            PH_CFGRD: begin
                cnt_last_o = CNT_W'(CFG_READS - 1);
                cnt_inc_o  = ack_i;
            end
            PH_WAIT: begin
                cnt_last_o = wait_last;
                cnt_inc_o  = 1'b1;
            end
            PH_REFR: begin
                cnt_last_o = CNT_W'(REF_BURST - 1);
                cnt_inc_o  = ack_i;
            end
            PH_REFIDLE: begin
                cnt_last_o = idle_last;
                cnt_inc_o  = 1'b1;
            end
            default: begin
                cnt_last_o = '0;
                cnt_inc_o  = 1'b0;
            end
        endcase
    end

    assign adv        = cnt_inc_o && at_last_i;
    assign cnt_clr_o  = adv;
    assign cfg_load_o = (state_q == PH_CFGRD) && adv;

    // Choose the next phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RST:     state_d = analyse_i ? PH_HOLD : PH_SETTLE;
            PH_SETTLE:  if (adv) state_d = PH_SCAN;
            PH_SCAN:    if (adv) state_d = PH_CFGRD;
            PH_CFGRD:   if (adv) state_d = PH_WAIT;
            PH_WAIT:    if (adv) state_d = ref_en_i ? PH_REFR : PH_REFIDLE;
            PH_REFR:    if (adv) state_d = PH_BOOT;
            PH_REFIDLE: if (adv) state_d = PH_BOOT;
            PH_HOLD:    if (!analyse_i) state_d = PH_BOOT;
            PH_BOOT:    state_d = PH_BOOT;
            default:    state_d = PH_RST;
        endcase
    end

    // Phase register; reset forces the reset phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Boot mode, chosen once on entry to boot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= BOOT_NONE;
        end else if ((state_d == PH_BOOT) && (state_q != PH_BOOT)) begin
            boot_q <= boot_rom_i ? BOOT_ROM : BOOT_LINK;
        end
    end

    // Link hold follows the sampled reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
        end else begin
            hold_q <= 1'b0;
        end
    end

    // Flag-clear strobe on a normal release only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fclr_q <= 1'b0;
        end else begin
            fclr_q <= (state_q == PH_RST) && !analyse_i;
        end
    end

    assign phase_o     = state_q;
    assign boot_o      = boot_q;
    assign link_hold_o = hold_q;
    assign flag_clr_o  = fclr_q;

    // R9: the flag-clear strobe is a single cycle
    p_fclr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fclr_q |=> !fclr_q)
        else $error("flag clear longer than one cycle");

    // R8: a chosen boot mode stays put
    p_boot_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q != BOOT_NONE) |=> $stable(boot_q))
        else $error("boot mode changed");

    // R8: a boot mode exists only in the boot phase
    p_boot_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q != BOOT_NONE) |-> (state_q == PH_BOOT))
        else $error("boot mode outside boot phase");

    // R10: the analyse hold only exits into boot
    p_hold_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD) |=> (state_q inside {PH_HOLD, PH_BOOT}))
        else $error("analyse hold left to a wrong phase");

    // R6: refresh cycles only with refresh enabled
    p_refr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_REFR) |-> ref_en_i)
        else $error("refresh phase with refresh disabled");

    // R7: idle replacement only with refresh disabled
    p_idle_dis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_REFIDLE) |-> !ref_en_i)
        else $error("idle phase with refresh enabled");

endmodule

// File: rtl/bootseq_top.sv
`timescale 1ns/1ps
// Start-up sequencer top: wires the phase sequencer, the shared counter
// and the configuration store, and decodes the request outputs.
// Assumes: mem_ack_i is a one-cycle strobe per completed memory cycle.
module bootseq_top
    import bootseq_pkg::*;
#(
    parameter int SETTLE_CYC = 144,
    parameter int SCAN_CYC   = 144,
    parameter int CFG_READS  = 36,
    parameter int REF_BURST  = 8,
    parameter int WAIT_W     = 8,
    parameter int REFLEN_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                analyse_i,
    input  logic                boot_rom_i,
    input  logic                refresh_en_i,
    input  logic [WAIT_W-1:0]   wait_len_i,
    input  logic [REFLEN_W-1:0] ref_len_i,
    input  logic                mem_ack_i,
    output logic [3:0]          phase_o,
    output logic                cfg_rd_req_o,
    output logic                ref_req_o,
    output logic                cfg_upd_o,
    output logic                flag_clr_o,
    output logic                link_hold_o,
    output logic [1:0]          boot_sel_o
);

    localparam int unsigned LIM_MAX = max_u(max_u(SETTLE_CYC, SCAN_CYC),
        max_u(CFG_READS, max_u(2 ** WAIT_W, REF_BURST * (2 ** REFLEN_W))));
    localparam int CNT_W = $clog2(LIM_MAX + 1);

    phase_e                phase;
    boot_e                 boot;
    logic                  cnt_clr;
    logic                  cnt_inc;
    logic [CNT_W-1:0]      cnt_last;
    logic                  at_last;
    logic                  cfg_load;
    logic [WAIT_W-1:0]     wait_q;
    logic [REFLEN_W-1:0]   rlen_q;
    logic                  ren_q;

    bootseq_fsm #(
        .SETTLE_CYC(SETTLE_CYC), .SCAN_CYC(SCAN_CYC), .CFG_READS(CFG_READS),
        .REF_BURST(REF_BURST), .WAIT_W(WAIT_W), .REFLEN_W(REFLEN_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .analyse_i(analyse_i), .boot_rom_i(boot_rom_i),
        .ack_i(mem_ack_i), .at_last_i(at_last), .wait_len_i(wait_q),
        .ref_len_i(rlen_q), .ref_en_i(ren_q), .phase_o(phase),
        .cnt_clr_o(cnt_clr), .cnt_inc_o(cnt_inc), .cnt_last_o(cnt_last),
        .cfg_load_o(cfg_load), .link_hold_o(link_hold_o),
        .flag_clr_o(flag_clr_o), .boot_o(boot)
    );

    bootseq_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .last_i(cnt_last), .at_last_o(at_last)
    );

    bootseq_cfgreg #(.WAIT_W(WAIT_W), .REFLEN_W(REFLEN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load), .wait_len_i(wait_len_i),
        .ref_len_i(ref_len_i), .ref_en_i(refresh_en_i), .wait_len_o(wait_q),
        .ref_len_o(rlen_q), .ref_en_o(ren_q), .upd_o(cfg_upd_o)
    );

    assign phase_o      = phase;
    assign boot_sel_o   = boot;
    assign cfg_rd_req_o = (phase == PH_CFGRD);
    assign ref_req_o    = (phase == PH_REFR);

    // R12: requests and boot modes are mutually exclusive
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_rd_req_o, ref_req_o, boot_sel_o}))
        else $error("overlapping request or boot outputs");

    // R1: link hold only while in the reset phase
    p_link_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RST) |-> !link_hold_o)
        else $error("link hold outside reset");

    // R1: the reset phase always holds the links
    p_link_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RST) |-> link_hold_o)
        else $error("reset phase without link hold");

endmodule

// File: tb/test_bootseq_top.sv
`timescale 1ns/1ps
module test_bootseq_top;

    localparam int WAIT_W   = 8;
    localparam int REFLEN_W = 6;
    localparam int SETTLE   = 144;
    localparam int SCAN     = 144;
    localparam int N_CFG    = 36;
    localparam int N_REF    = 8;

    localparam logic [3:0] C_RST  = 4'd0;
    localparam logic [3:0] C_SET  = 4'd1;
    localparam logic [3:0] C_SCAN = 4'd2;
    localparam logic [3:0] C_CFG  = 4'd3;
    localparam logic [3:0] C_WAIT = 4'd4;
    localparam logic [3:0] C_REFR = 4'd5;
    localparam logic [3:0] C_IDLE = 4'd6;
    localparam logic [3:0] C_HOLD = 4'd7;
    localparam logic [3:0] C_BOOT = 4'd8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                analyse;
    logic                boot_rom;
    logic                refresh_en;
    logic [WAIT_W-1:0]   wait_len;
    logic [REFLEN_W-1:0] ref_len;
    logic                mem_ack;
    logic [3:0]          phase;
    logic                cfg_rd_req;
    logic                ref_req;
    logic                cfg_upd;
    logic                flag_clr;
    logic                link_hold;
    logic [1:0]          boot_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bootseq_top i_bootseq_top (
        .clk(clk), .rst_n(rst_n), .analyse_i(analyse), .boot_rom_i(boot_rom),
        .refresh_en_i(refresh_en), .wait_len_i(wait_len), .ref_len_i(ref_len),
        .mem_ack_i(mem_ack), .phase_o(phase), .cfg_rd_req_o(cfg_rd_req),
        .ref_req_o(ref_req), .cfg_upd_o(cfg_upd), .flag_clr_o(flag_clr),
        .link_hold_o(link_hold), .boot_sel_o(boot_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(int w);
        return (w == 0) ? 1 : w;
    endfunction

    function automatic int exp_idle(int r);
        return N_REF * ((r == 0) ? 1 : r);
    endfunction

    function automatic int exp_boot(bit rom);
        return rom ? 1 : 2;
    endfunction

    // Timed phase: exact length, no requests, random stray acks (R4).
    task automatic stay(input logic [3:0] ph, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            chk(phase == ph && !cfg_rd_req && !ref_req, req, int'(phase), int'(ph));
            mem_ack = ($urandom % 2) == 1;
            @(negedge clk);
        end
    endtask

    // Counted phase: ends on the n-th acknowledge.
    task automatic acked(input logic [3:0] ph, input int n, input string req);
        int got;
        got = 0;
        while (got < n) begin
            chk(phase == ph && ((ph == C_CFG) ? cfg_rd_req : ref_req),
                req, int'(phase), int'(ph));
            mem_ack = ($urandom % 3) != 0;
            if (mem_ack) got++;
            @(negedge clk);
        end
        mem_ack = 1'b0;
    endtask

    // Hold reset for k cycles; R1 and R11 checked every cycle.
    task automatic apply_reset(input bit ana, input int k);
        rst_n   = 1'b0;
        analyse = ana;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(link_hold == 1'b1, "R1", int'(link_hold), 1);
            chk(phase == C_RST, "R11", int'(phase), int'(C_RST));
        end
    endtask

    task automatic run_normal(input int w, input int r, input bit ren, input bit rom);
        wait_len   = WAIT_W'(w);
        ref_len    = REFLEN_W'(r);
        refresh_en = ren;
        boot_rom   = rom;
        apply_reset(1'b0, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(link_hold == 1'b0, "R1", int'(link_hold), 0);
        chk(flag_clr == 1'b1, "R9", int'(flag_clr), 1);
        stay(C_SET, SETTLE, "R2");
        chk(flag_clr == 1'b0, "R9", int'(flag_clr), 0);
        stay(C_SCAN, SCAN, "R3");
        acked(C_CFG, N_CFG, "R4");
        chk(cfg_upd == 1'b1, "R5", int'(cfg_upd), 1);
        wait_len   = WAIT_W'($urandom);
        ref_len    = REFLEN_W'($urandom);
        refresh_en = ~ren;
        stay(C_WAIT, exp_wait(w), "R5");
        if (ren) begin
            acked(C_REFR, N_REF, "R6");
        end else begin
            stay(C_IDLE, exp_idle(r), "R7");
        end
        chk(phase == C_BOOT, "R8", int'(phase), int'(C_BOOT));
        chk(int'(boot_sel) == exp_boot(rom), "R8", int'(boot_sel), exp_boot(rom));
        boot_rom = ~rom;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(int'(boot_sel) == exp_boot(rom), "R8", int'(boot_sel), exp_boot(rom));
        end
    endtask

    task automatic run_analyse(input int hold, input bit rom);
        boot_rom = ~rom;
        apply_reset(1'b1, 3);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < hold; i++) begin
            chk(phase == C_HOLD, "R10", int'(phase), int'(C_HOLD));
            chk(!cfg_rd_req && !ref_req && !cfg_upd && boot_sel == 2'b00,
                "R10", int'({cfg_rd_req, ref_req, cfg_upd, boot_sel}), 0);
            chk(flag_clr == 1'b0, "R9", int'(flag_clr), 0);
            mem_ack = ($urandom % 2) == 1;
            @(negedge clk);
        end
        analyse  = 1'b0;
        boot_rom = rom;
        @(negedge clk);
        chk(phase == C_BOOT, "R10", int'(phase), int'(C_BOOT));
        chk(int'(boot_sel) == exp_boot(rom), "R10", int'(boot_sel), exp_boot(rom));
    endtask

    task automatic run_abort(input int cyc);
        wait_len   = 8'd3;
        ref_len    = 6'd2;
        refresh_en = 1'b1;
        apply_reset(1'b0, 2);
        rst_n = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            mem_ack = ($urandom % 2) == 1;
        end
        apply_reset(1'b0, 2);
    endtask

    initial begin
        rst_n      = 1'b0;
        analyse    = 1'b0;
        boot_rom   = 1'b0;
        refresh_en = 1'b0;
        wait_len   = '0;
        ref_len    = '0;
        mem_ack    = 1'b0;
        void'($urandom(32'hB007));
        @(negedge clk);
        run_normal(0, 0, 1'b1, 1'b1);
        run_normal(1, 63, 1'b0, 1'b0);
        run_normal(255, 0, 1'b0, 1'b1);
        run_normal(7, 1, 1'b1, 1'b0);
        run_analyse(5, 1'b1);
        run_analyse(1, 1'b0);
        run_abort(40);
        run_abort(200);
        run_abort(320);
        for (int t = 0; t < 6; t++) begin
            run_normal(int'($urandom % 256), int'($urandom % 64),
                       ($urandom % 2) == 1, ($urandom % 2) == 1);
            if (($urandom % 2) == 1) begin
                run_analyse(1 + int'($urandom % 20), ($urandom % 2) == 1);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule